// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit decides, once per clock, whether the pending interrupt level presented by the interrupt controller may interrupt the processor. If it may, the unit computes the processor state that follows acceptance and holds it in registers on the next clock edge. That state is the new program counter, the new status word, the per-level saved PC and saved status, the double-exception PC, the exception cause and the exception kind. A one-cycle pulse marks each acceptance. When no interrupt is accepted, every held output keeps its value.

Levels 2 and above are high-priority levels. Each jumps straight to its own vector and saves the interrupted PC and status word in registers that belong to that level. Level 1 does not get a vector of its own. It is turned into a general exception: a user, kernel or double exception, chosen from the exception-mode and user-mode bits of the status word. Vector addresses can follow a vector base supplied at run time, or they can be fixed at build time.

Status word layout used throughout: bits [3:0] hold the current interrupt level, bit 4 is the exception-mode bit and bit 5 is the user-mode bit. Vector slots are spaced `VEC_STRIDE` apart: slot 1 is the user exception, slot 2 the kernel exception, slot 3 the double exception, and slot L+2 is high level L.

Top module: `irq_dispatch_unit`

## Requirements
- R1: While reset is asserted, `pc_o` equals `RESET_VEC`, and `ps_o` equals 0x1F if `INT_OPT` is set or 0x10 otherwise. `taken_o`, `exccause_o`, `exc_kind_o`, `depc_o` and every saved-PC and saved-status slot are zero.
- R2: A level L is accepted only if three conditions all hold: L is greater than `ps_i[3:0]`, L is at most `NUM_LEVELS`, and the bitwise AND of level L's mask, `intset_i` and `intenable_i` is nonzero. When a level is not accepted, no output changes on the next edge and `taken_o` is 0.
- R3: When a level L of 2 or more is accepted, the next edge stores `pc_i` in saved-PC slot L and `ps_i` in saved-status slot L. It also sets `ps_o` to `ps_i` with bits [3:0] replaced by L and bit 4 set, sets `exc_kind_o` to 0 (none), and moves `pc_o` to the vector for slot L+2.
- R4: When level 1 is accepted, `exccause_o` becomes 4 on the next edge. Higher levels leave `exccause_o` unchanged.
- R5: When level 1 is accepted while `ps_i` bit 4 is set, `exc_kind_o` becomes 3 (double) and `pc_o` moves to slot 3. `pc_i` goes to `depc_o` if `HAS_DEPC` is set, or to saved-PC slot 1 otherwise.
- R6: When level 1 is accepted while `ps_i` bit 4 is clear, `pc_i` goes to saved-PC slot 1. `exc_kind_o` becomes 1 (user, slot 1) if `ps_i` bit 5 is set, or 2 (kernel, slot 2) otherwise.
- R7: In every level-1 case, `ps_o` becomes `ps_i` with bit 4 set and the other bits unchanged.
- R8: With `RELOC_EN` set, the vector for slot s is `vecbase_i + s*VEC_STRIDE`, which equals the default vector minus `DEF_VECBASE` plus the run-time base. With `RELOC_EN` clear, it is `DEF_VECBASE + s*VEC_STRIDE` and `vecbase_i` has no effect.
- R9: `taken_o` is high for exactly the cycle after each edge at which a level is accepted.
- R10: A pending level above `NUM_LEVELS` is never accepted, even when `intset_i` and `intenable_i` are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_level_i | input | 4 | Pending interrupt level, 0 when nothing is pending |
| ps_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| level_mask_i | input | NUM_LEVELS*XLEN | Interrupt mask per level; level L occupies slice L-1 |
| intset_i | input | XLEN | Raised interrupt lines |
| intenable_i | input | XLEN | Enabled interrupt lines |
| vecbase_i | input | XLEN | Run-time vector base |
| pc_o | output | XLEN | New program counter |
| ps_o | output | XLEN | Updated status word |
| epc_o | output | NUM_LEVELS*XLEN | Saved PC; level L occupies slice L-1 |
| eps_o | output | (NUM_LEVELS-1)*XLEN | Saved status; level L occupies slice L-2 |
| depc_o | output | XLEN | Double-exception saved PC |
| exccause_o | output | XLEN | Exception cause |
| exc_kind_o | output | 2 | 0 none, 1 user, 2 kernel, 3 double |
| taken_o | output | 1 | One-cycle pulse after an acceptance |

## Verification
The bench builds two copies of the unit and drives both with the same stimulus. The first copy uses the defaults: six levels, a double-exception PC register, run-time relocation, and the interrupt option present. The second copy has no double-exception register, uses fixed vectors and does not have the interrupt option. This pairing exercises both destinations of the double-exception PC, both reset values of the status word, and both ways of forming a vector. It also shows that a change of run-time base moves one copy's vectors but not the other's.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int LVL_W       = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;
  localparam int SLOT_W      = 5;

  localparam logic [SLOT_W-1:0] SLOT_USER   = 5'd1;
  localparam logic [SLOT_W-1:0] SLOT_KERNEL = 5'd2;
  localparam logic [SLOT_W-1:0] SLOT_DOUBLE = 5'd3;
  localparam logic [SLOT_W-1:0] SLOT_HI_OFS = 5'd2;

  localparam int CAUSE_LEVEL1 = 4;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_USER   = 2'd1,
    EXC_KERNEL = 2'd2,
    EXC_DOUBLE = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/irq_accept.sv
module irq_accept
  import irq_disp_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int XLEN       = 32
) (
  input  logic [LVL_W-1:0]           lvl_i,
  input  logic [LVL_W-1:0]           cur_lvl_i,
  input  logic [NUM_LEVELS*XLEN-1:0] mask_i,
  input  logic [XLEN-1:0]            intset_i,
  input  logic [XLEN-1:0]            intenable_i,
  output logic                       accept_o
);
  logic [XLEN-1:0] sel_mask;
  logic            in_range;

  always_comb begin
    sel_mask = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (lvl_i == LVL_W'(l)) sel_mask = mask_i[(l-1)*XLEN +: XLEN];
    end
  end

  assign in_range = (int'(lvl_i) <= NUM_LEVELS);
  assign accept_o = (lvl_i > cur_lvl_i) && in_range &&
                    (|(sel_mask & intset_i & intenable_i));
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_disp_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0040
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [XLEN-1:0]   vecbase_i,
  output logic [XLEN-1:0]   vec_o
);
  logic [XLEN-1:0] offset;
  assign offset = XLEN'(slot_i) * VEC_STRIDE;

  if (RELOC_EN) begin : g_reloc
    // default - DEF_VECBASE + vecbase reduces to vecbase + offset
    assign vec_o = vecbase_i + offset;
  end else begin : g_fixed
    logic unused_base;
    assign unused_base = ^vecbase_i;
    assign vec_o = DEF_VECBASE + offset;
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_disp_pkg::*;
#(
  parameter int              NUM_LEVELS = 6,
  parameter int              XLEN       = 32,
  parameter bit              HAS_DEPC   = 1'b1,
  parameter bit              INT_OPT    = 1'b1,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'h5000_0000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           accept_i,
  input  logic [LVL_W-1:0]               lvl_i,
  input  logic [XLEN-1:0]                pc_i,
  input  logic [XLEN-1:0]                ps_i,
  input  logic [XLEN-1:0]                vec_i,
  output logic [XLEN-1:0]                pc_o,
  output logic [XLEN-1:0]                ps_o,
  output logic [NUM_LEVELS*XLEN-1:0]     epc_o,
  output logic [(NUM_LEVELS-1)*XLEN-1:0] eps_o,
  output logic [XLEN-1:0]                depc_o,
  output logic [XLEN-1:0]                exccause_o,
  output logic [1:0]                     exc_kind_o,
  output logic                           taken_o
);
  localparam logic [XLEN-1:0] PS_RST    = INT_OPT ? XLEN'(32'h1F) : XLEN'(32'h10);
  localparam logic [XLEN-1:0] EXCM_MASK = XLEN'(1) << PS_EXCM_BIT;
  localparam logic [XLEN-1:0] LVL_MASK  = XLEN'(4'hF);

  logic      hi, excm, um;
  exc_kind_e kind_q;

  assign hi   = lvl_i > LVL_W'(1);
  assign excm = ps_i[PS_EXCM_BIT];
  assign um   = ps_i[PS_UM_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= RESET_VEC;
      ps_o       <= PS_RST;
      exccause_o <= '0;
      kind_q     <= EXC_NONE;
      taken_o    <= 1'b0;
    end else begin
      taken_o <= accept_i;
      if (accept_i) begin
        pc_o <= vec_i;
        if (hi) begin
          ps_o   <= (ps_i & ~LVL_MASK) | XLEN'(lvl_i) | EXCM_MASK;
          kind_q <= EXC_NONE;
        end else begin
          ps_o       <= ps_i | EXCM_MASK;
          exccause_o <= XLEN'(CAUSE_LEVEL1);
          kind_q     <= excm ? EXC_DOUBLE : (um ? EXC_USER : EXC_KERNEL);
        end
      end
    end
  end
  assign exc_kind_o = kind_q;

  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_epc
    logic            we;
    logic [XLEN-1:0] q;
    if (l == 1) begin : g_l1
      assign we = accept_i && !hi && (!excm || !HAS_DEPC);
    end else begin : g_hi
      assign we = accept_i && (lvl_i == LVL_W'(l));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (we)  q <= pc_i;
    end
    assign epc_o[(l-1)*XLEN +: XLEN] = q;
  end

  for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_eps
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (accept_i && lvl_i == LVL_W'(l))     q <= ps_i;
    end
    assign eps_o[(l-2)*XLEN +: XLEN] = q;
  end

  if (HAS_DEPC) begin : g_depc
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q <= '0;
      else if (accept_i && !hi && excm)    q <= pc_i;
    end
    assign depc_o = q;
  end else begin : g_no_depc
    assign depc_o = '0;
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(pc_o) && $stable(ps_o) && $stable(epc_o) &&
                   $stable(eps_o) && $stable(exccause_o) && !taken_o));
  assert_hi_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && lvl_i > 4'd1) |=> (ps_o[3:0] == $past(lvl_i) && pc_o == $past(vec_i)));
  assert_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && lvl_i == 4'd1) |=> (exccause_o == XLEN'(CAUSE_LEVEL1)));
  assert_double_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && lvl_i == 4'd1 && ps_i[PS_EXCM_BIT]) |=> (exc_kind_o == EXC_DOUBLE));
  assert_excm_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> ps_o[PS_EXCM_BIT]);
  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> taken_o);
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
  import irq_disp_pkg::*;
#(
  parameter int              NUM_LEVELS  = 6,
  parameter int              XLEN        = 32,
  parameter bit              HAS_DEPC    = 1'b1,
  parameter bit              INT_OPT     = 1'b1,
  parameter bit              RELOC_EN    = 1'b1,
  parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE  = 32'h0000_0040,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h5000_0000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [3:0]                     irq_level_i,
  input  logic [XLEN-1:0]                ps_i,
  input  logic [XLEN-1:0]                pc_i,
  input  logic [NUM_LEVELS*XLEN-1:0]     level_mask_i,
  input  logic [XLEN-1:0]                intset_i,
  input  logic [XLEN-1:0]                intenable_i,
  input  logic [XLEN-1:0]                vecbase_i,
  output logic [XLEN-1:0]                pc_o,
  output logic [XLEN-1:0]                ps_o,
  output logic [NUM_LEVELS*XLEN-1:0]     epc_o,
  output logic [(NUM_LEVELS-1)*XLEN-1:0] eps_o,
  output logic [XLEN-1:0]                depc_o,
  output logic [XLEN-1:0]                exccause_o,
  output logic [1:0]                     exc_kind_o,
  output logic                           taken_o
);
  logic              accept;
  logic [SLOT_W-1:0] slot;
  logic [XLEN-1:0]   vec;

  irq_accept #(.NUM_LEVELS(NUM_LEVELS), .XLEN(XLEN)) u_accept (
    .lvl_i       (irq_level_i),
    .cur_lvl_i   (ps_i[LVL_W-1:0]),
    .mask_i      (level_mask_i),
    .intset_i    (intset_i),
    .intenable_i (intenable_i),
    .accept_o    (accept)
  );

  always_comb begin
    if (irq_level_i > LVL_W'(1))   slot = SLOT_W'(irq_level_i) + SLOT_HI_OFS;
    else if (ps_i[PS_EXCM_BIT])    slot = SLOT_DOUBLE;
    else if (ps_i[PS_UM_BIT])      slot = SLOT_USER;
    else                           slot = SLOT_KERNEL;
  end

  irq_vector_gen #(
    .XLEN(XLEN), .RELOC_EN(RELOC_EN),
    .DEF_VECBASE(DEF_VECBASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_vec (
    .slot_i    (slot),
    .vecbase_i (vecbase_i),
    .vec_o     (vec)
  );

  irq_state_regs #(
    .NUM_LEVELS(NUM_LEVELS), .XLEN(XLEN), .HAS_DEPC(HAS_DEPC),
    .INT_OPT(INT_OPT), .RESET_VEC(RESET_VEC)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .lvl_i      (irq_level_i),
    .pc_i       (pc_i),
    .ps_i       (ps_i),
    .vec_i      (vec),
    .pc_o       (pc_o),
    .ps_o       (ps_o),
    .epc_o      (epc_o),
    .eps_o      (eps_o),
    .depc_o     (depc_o),
    .exccause_o (exccause_o),
    .exc_kind_o (exc_kind_o),
    .taken_o    (taken_o)
  );

  assert_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(irq_level_i) > NUM_LEVELS) |=> !taken_o);
  assert_level_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_i <= ps_i[LVL_W-1:0]) |=> !taken_o);
endmodule

// File: tb/irq_dispatch_unit_tb.sv
module irq_dispatch_unit_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          W   = 32;
  localparam int          NL  = 6;
  localparam logic [31:0] DVB = 32'h4000_0000;
  localparam logic [31:0] STR = 32'h0000_0040;
  localparam logic [31:0] RV  = 32'h5000_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0]      irq_level;
  logic [W-1:0]    ps, pc, intset, inten, vecbase;
  logic [NL*W-1:0] masks;

  logic [W-1:0]        a_pc, a_ps, a_depc, a_cause, b_pc, b_ps, b_depc, b_cause;
  logic [NL*W-1:0]     a_epc, b_epc;
  logic [(NL-1)*W-1:0] a_eps, b_eps;
  logic [1:0]          a_kind, b_kind;
  logic                a_taken, b_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_level_i(irq_level), .ps_i(ps), .pc_i(pc),
    .level_mask_i(masks), .intset_i(intset), .intenable_i(inten), .vecbase_i(vecbase),
    .pc_o(a_pc), .ps_o(a_ps), .epc_o(a_epc), .eps_o(a_eps), .depc_o(a_depc),
    .exccause_o(a_cause), .exc_kind_o(a_kind), .taken_o(a_taken));

  irq_dispatch_unit #(.HAS_DEPC(1'b0), .INT_OPT(1'b0), .RELOC_EN(1'b0)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_ni), .irq_level_i(irq_level), .ps_i(ps), .pc_i(pc),
    .level_mask_i(masks), .intset_i(intset), .intenable_i(inten), .vecbase_i(vecbase),
    .pc_o(b_pc), .ps_o(b_ps), .epc_o(b_epc), .eps_o(b_eps), .depc_o(b_depc),
    .exccause_o(b_cause), .exc_kind_o(b_kind), .taken_o(b_taken));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] epc_of(input logic [NL*W-1:0] v, input int l);
    return v[(l-1)*W +: W];
  endfunction

  function automatic logic [31:0] eps_of(input logic [(NL-1)*W-1:0] v, input int l);
    return v[(l-2)*W +: W];
  endfunction

  task automatic set_mask(input int l, input logic [31:0] m);
    masks = '0;
    masks[(l-1)*W +: W] = m;
  endtask

  // drop the request and confirm the pulse ends
  task automatic idle(input string tag);
    irq_level = 4'd0;
    tick();
    chk({tag, " R9 taken falls"}, 32'(a_taken), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 pc", a_pc, RV);
    chk("R1 ps int opt", a_ps, 32'h1F);
    chk("R1 ps no int opt", b_ps, 32'h10);
    chk("R1 taken", 32'(a_taken), 32'd0);
    chk("R1 cause", a_cause, 32'd0);
    chk("R1 kind", 32'(a_kind), 32'd0);
    chk("R1 epc1", epc_of(a_epc, 1), 32'd0);
    chk("R1 eps6", eps_of(a_eps, 6), 32'd0);
    chk("R1 depc", a_depc, 32'd0);
  endtask

  task automatic t_high_level();
    irq_level = 4'd3; ps = 32'h0000_0102; pc = 32'h1000_0040;
    set_mask(3, 32'h20); intset = 32'h220; inten = 32'h20;
    tick();
    chk("R9 taken", 32'(a_taken), 32'd1);
    chk("R3 epc3", epc_of(a_epc, 3), 32'h1000_0040);
    chk("R3 eps3", eps_of(a_eps, 3), 32'h0000_0102);
    chk("R3 ps", a_ps, 32'h0000_0113);
    chk("R3 kind", 32'(a_kind), 32'd0);
    chk("R8 reloc pc", a_pc, 32'h8000_0140);
    chk("R8 fixed pc", b_pc, DVB + 32'd5 * STR);
    chk("R4 cause untouched", a_cause, 32'd0);
    idle("high");
    chk("R2 pc held", a_pc, 32'h8000_0140);
  endtask

  task automatic t_reject_level();
    irq_level = 4'd3; ps = 32'h3; pc = 32'h1111_0000;
    set_mask(3, 32'hFFFF_FFFF); intset = '1; inten = '1;
    tick();
    chk("R2 not greater taken", 32'(a_taken), 32'd0);
    chk("R2 not greater epc3", epc_of(a_epc, 3), 32'h1000_0040);
    chk("R2 not greater pc", a_pc, 32'h8000_0140);
    idle("rej lvl");
  endtask

  task automatic t_reject_enable();
    irq_level = 4'd4; ps = 32'h0; pc = 32'h2222_0000;
    set_mask(4, 32'h80); intset = 32'h80; inten = 32'h0;
    tick();
    chk("R2 disabled taken", 32'(a_taken), 32'd0);
    chk("R2 disabled epc4", epc_of(a_epc, 4), 32'd0);
    intset = 32'h100; inten = '1;
    tick();
    chk("R2 masked taken", 32'(a_taken), 32'd0);
    chk("R2 masked ps", a_ps, 32'h0000_0113);
    idle("rej en");
  endtask

  task automatic t_range();
    irq_level = 4'd7; ps = 32'h0; pc = 32'h3333_0000;
    masks = '1; intset = '1; inten = '1;
    tick();
    chk("R10 level 7 taken", 32'(a_taken), 32'd0);
    irq_level = 4'd15;
    tick();
    chk("R10 level 15 taken", 32'(a_taken), 32'd0);
    chk("R10 pc held", a_pc, 32'h8000_0140);
    idle("range");
  endtask

  task automatic t_l1_kernel();
    irq_level = 4'd1; ps = 32'h0; pc = 32'h2000_0010;
    set_mask(1, 32'h1); intset = 32'h1; inten = 32'h1;
    tick();
    chk("R4 cause", a_cause, 32'd4);
    chk("R6 kernel kind", 32'(a_kind), 32'd2);
    chk("R6 epc1", epc_of(a_epc, 1), 32'h2000_0010);
    chk("R7 ps", a_ps, 32'h10);
    chk("R8 kernel vec", a_pc, 32'h8000_0080);
    chk("R8 fixed kernel vec", b_pc, DVB + 32'd2 * STR);
    idle("l1 kernel");
  endtask

  task automatic t_l1_user();
    irq_level = 4'd1; ps = 32'h20; pc = 32'h2000_0020;
    tick();
    chk("R6 user kind", 32'(a_kind), 32'd1);
    chk("R6 user epc1", epc_of(a_epc, 1), 32'h2000_0020);
    chk("R7 user ps", a_ps, 32'h30);
    chk("R8 user vec", a_pc, 32'h8000_0040);
    idle("l1 user");
  endtask

  task automatic t_l1_double();
    irq_level = 4'd1; ps = 32'h10; pc = 32'h2000_0030;
    tick();
    chk("R5 double kind", 32'(a_kind), 32'd3);
    chk("R5 depc", a_depc, 32'h2000_0030);
    chk("R5 epc1 kept", epc_of(a_epc, 1), 32'h2000_0020);
    chk("R5 no depc epc1", epc_of(b_epc, 1), 32'h2000_0030);
    chk("R5 no depc reg", b_depc, 32'd0);
    chk("R5 double vec", a_pc, 32'h8000_00C0);
    chk("R7 double ps", a_ps, 32'h10);
    chk("R4 double cause", b_cause, 32'd4);
    idle("l1 double");
  endtask

  task automatic t_reloc();
    vecbase = 32'h9000_0000;
    irq_level = 4'd6; ps = 32'h5; pc = 32'h3000_0000;
    set_mask(6, 32'h8000_0000); intset = 32'h8000_0000; inten = 32'h8000_0000;
    tick();
    chk("R8 new base", a_pc, 32'h9000_0200);
    chk("R8 base ignored", b_pc, DVB + 32'd8 * STR);
    chk("R3 eps6", eps_of(a_eps, 6), 32'h5);
    chk("R3 ps6", a_ps, 32'h16);
    idle("reloc");
    irq_level = 4'd2; ps = 32'h1; pc = 32'h3000_0004;
    set_mask(2, 32'h2); intset = 32'h2; inten = 32'h2;
    tick();
    chk("R3 epc2", epc_of(a_epc, 2), 32'h3000_0004);
    chk("R3 eps2", eps_of(a_eps, 2), 32'h1);
    chk("R3 lvl2 vec", a_pc, 32'h9000_0100);
    chk("R4 cause kept", a_cause, 32'd4);
    idle("lvl2");
  endtask

  initial begin
    irq_level = '0; ps = '0; pc = '0; masks = '0;
    intset = '0; inten = '0; vecbase = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_high_level();
    t_reject_level();
    t_reject_enable();
    t_range();
    t_l1_kernel();
    t_l1_user();
    t_l1_double();
    t_reloc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule